// File: doc/BRIEF.md
# Matrix Keypad Scanner

This block scans a keypad wired as a grid of row lines and column lines, eight by eight by default, so up to 64 keys. While nothing is pressed it rests with every row line driven high and watches the column lines. A pressed key connects its row to its column, so with all rows high any press makes some column read high.

When a column goes high, a small state machine starts scanning with no processor involvement. It drives one row at a time and lets each row settle for a programmable number of scan-rate ticks. It then captures the synchronized column inputs into that row's slot of a frame map. A complete frame is accepted only after the same map has been seen on a programmable number of consecutive frames. An accepted map that differs from the published one replaces it, and a one-cycle interrupt is raised at the same time. Once the accepted map is empty, the machine goes back to resting with all rows high.

Top module: `keymat_scan`

## Requirements
- R1: While reset is asserted and right after it, every row output is high, the key map is all zero and the interrupt is low.
- R2: The machine leaves the resting state only on a cycle where `scan_tick` is high and at least one synchronized column input is high. The first row it drives is row 0.
- R3: While scanning, exactly one row output is high. Rows are visited in ascending order 0 to ROWS-1 and then wrap to row 0.
- R4: Each row stays driven for `settle_ticks` ticks of `scan_tick`, with 0 treated as 1. A row changes only on a clock edge where `scan_tick` is high. With a tick every 6 clocks and `settle_ticks` = 3, a row is held for 18 clocks.
- R5: A key at row r and column c is reported in bit r*COLS + c of `key_map`. Column c is input bit c and row r is output bit r.
- R6: A frame map is accepted only once it has been seen on `stable_scans` consecutive frames, with 0 treated as 1. Any differing frame restarts the count, so a pattern that lasts fewer frames than required has no effect on `key_map` or `key_irq`.
- R7: When an accepted map differs from `key_map`, `key_map` takes the new value and `key_irq` is high for exactly one cycle on the same edge. `key_map` changes at no other time.
- R8: On the edge where an all-zero map is accepted, the machine returns to the resting state with all rows high. If the accepted map is not empty, scanning continues from row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_tick | input | 1 | One-cycle scan-rate strobe; its period must be at least 3 clocks |
| settle_ticks | input | SETTLE_W | Ticks each row is held before sampling (0 means 1) |
| stable_scans | input | DEB_W | Consecutive matching frames needed for acceptance (0 means 1) |
| col_in | input | COLS | Raw column lines, high where a driven row meets a pressed key |
| row_out | output | ROWS | Row drive lines |
| key_map | output | ROWS*COLS | Published debounced key state |
| key_irq | output | 1 | One-cycle pulse when `key_map` changes |

## Verification
The bench goes after the first frame after wake-up. An off-by-one in the frame counter would fire the interrupt one frame early or late, and it would lose the single-frame setting where 0 must act as 1. A short column blip that wakes the scanner and then vanishes must return it to rest silently; a design that published the empty frame or stayed awake would be caught. A pattern that flickers for one frame while a key is held must not disturb the map, which exposes a count that fails to restart. Corner keys, full rows, full columns and the all-keys pattern expose swapped row and column indexing. A measured row hold time catches settle counts that are off by one tick.

// File: rtl/keymat_pkg.sv
package keymat_pkg;
   typedef enum logic {
      ST_REST = 1'b0,
      ST_SCAN = 1'b1
   } scan_st_e;
endpackage

// File: rtl/keymat_sync.sv
module keymat_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg <= '0;
      end else begin
         stg[0] <= din;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign dout = stg[STAGES-1];
endmodule

// File: rtl/keymat_rowseq.sv
module keymat_rowseq
   import keymat_pkg::*;
#(
   parameter int ROWS     = 8,
   parameter int SETTLE_W = 4,
   parameter int RW       = (ROWS > 1) ? $clog2(ROWS) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic [SETTLE_W-1:0] settle_ticks,
   input  logic                col_any,
   input  logic                go_idle,
   output logic [ROWS-1:0]     row_drv,
   output logic [RW-1:0]       row_idx,
   output logic                sample,
   output logic                last_row
);
   scan_st_e            st;
   logic [SETTLE_W-1:0] hold_cnt;
   logic [SETTLE_W:0]   need;
   logic                hold_done;

   assign need      = (settle_ticks == '0) ? (SETTLE_W+1)'(1) : {1'b0, settle_ticks};
   assign hold_done = ({1'b0, hold_cnt} + (SETTLE_W+1)'(1)) >= need;
   assign last_row  = (row_idx == RW'(ROWS-1));
   assign sample    = (st == ST_SCAN) && tick && hold_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_REST;
         row_idx  <= '0;
         hold_cnt <= '0;
      end else begin
         case (st)
            ST_REST: begin
               if (tick && col_any) begin
                  st       <= ST_SCAN;
                  row_idx  <= '0;
                  hold_cnt <= '0;
               end
            end
            default: begin
               if (tick) begin
                  if (hold_done) begin
                     hold_cnt <= '0;
                     if (last_row) begin
                        row_idx <= '0;
                        if (go_idle) st <= ST_REST;
                     end else begin
                        row_idx <= row_idx + 1'b1;
                     end
                  end else begin
                     hold_cnt <= hold_cnt + 1'b1;
                  end
               end
            end
         endcase
      end
   end

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      assign row_drv[r] = (st == ST_REST) || (row_idx == RW'(r));
   end
endmodule

// File: rtl/keymat_debounce.sv
module keymat_debounce #(
   parameter int MW    = 64,
   parameter int DEB_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_valid,
   input  logic [MW-1:0]    frame_map,
   input  logic [DEB_W-1:0] stable_scans,
   output logic [MW-1:0]    key_map,
   output logic             key_irq,
   output logic             go_idle
);
   logic [MW-1:0]    prev_map;
   logic [DEB_W-1:0] match_cnt;
   logic [DEB_W-1:0] new_cnt;
   logic [DEB_W-1:0] need;
   logic             same;
   logic             accept;

   assign need    = (stable_scans == '0) ? DEB_W'(1) : stable_scans;
   assign same    = (match_cnt != '0) && (frame_map == prev_map);
   assign new_cnt = !same ? DEB_W'(1)
                  : (match_cnt == '1) ? match_cnt : match_cnt + 1'b1;
   assign accept  = frame_valid && (new_cnt >= need);
   assign go_idle = accept && (frame_map == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_map  <= '0;
         match_cnt <= '0;
         key_map   <= '0;
         key_irq   <= 1'b0;
      end else begin
         key_irq <= 1'b0;
         if (frame_valid) begin
            prev_map  <= frame_map;
            match_cnt <= new_cnt;
            if (accept && (frame_map != key_map)) begin
               key_map <= frame_map;
               key_irq <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/keymat_scan.sv
module keymat_scan #(
   parameter int ROWS        = 8,
   parameter int COLS        = 8,
   parameter int SETTLE_W    = 4,
   parameter int DEB_W       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 scan_tick,
   input  logic [SETTLE_W-1:0]  settle_ticks,
   input  logic [DEB_W-1:0]     stable_scans,
   input  logic [COLS-1:0]      col_in,
   output logic [ROWS-1:0]      row_out,
   output logic [ROWS*COLS-1:0] key_map,
   output logic                 key_irq
);
   localparam int MW = ROWS * COLS;
   localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;

   initial begin
      assert (ROWS >= 2 && ROWS <= 32) else $error("keymat_scan: ROWS out of range");
      assert (COLS >= 1 && COLS <= 32) else $error("keymat_scan: COLS out of range");
      assert (SYNC_STAGES >= 2) else $error("keymat_scan: need two or more sync stages");
      assert (SETTLE_W >= 1 && DEB_W >= 1) else $error("keymat_scan: counter widths");
   end

   logic [COLS-1:0]            col_sync;
   logic [RW-1:0]              row_idx;
   logic                       sample;
   logic                       last_row;
   logic                       go_idle;
   logic [ROWS-1:0][COLS-1:0]  row_hold;
   logic [MW-1:0]              frame_map;

   keymat_sync #(.W(COLS), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (col_in),
      .dout (col_sync)
   );

   keymat_rowseq #(.ROWS(ROWS), .SETTLE_W(SETTLE_W), .RW(RW)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (scan_tick),
      .settle_ticks(settle_ticks),
      .col_any     (|col_sync),
      .go_idle     (go_idle),
      .row_drv     (row_out),
      .row_idx     (row_idx),
      .sample      (sample),
      .last_row    (last_row)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) row_hold <= '0;
      else if (sample) row_hold[row_idx] <= col_sync;
   end

   for (genvar r = 0; r < ROWS; r++) begin : g_frame
      assign frame_map[r*COLS +: COLS] = (row_idx == RW'(r)) ? col_sync : row_hold[r];
   end

   keymat_debounce #(.MW(MW), .DEB_W(DEB_W)) u_deb (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_valid (sample && last_row),
      .frame_map   (frame_map),
      .stable_scans(stable_scans),
      .key_map     (key_map),
      .key_irq     (key_irq),
      .go_idle     (go_idle)
   );
endmodule

// File: rtl/keymat_scan_chk.sv
module keymat_scan_chk #(
   parameter int ROWS = 8,
   parameter int COLS = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 scan_tick,
   input logic [ROWS-1:0]      row_out,
   input logic [COLS-1:0]      col_sync,
   input logic [ROWS*COLS-1:0] key_map,
   input logic                 key_irq
);
   localparam logic [ROWS-1:0] ALL = {ROWS{1'b1}};

   // R3
   row_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (row_out == ALL) || $onehot(row_out));

   // R3
   row_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (row_out != ALL && $past(row_out) != ALL && row_out != $past(row_out))
      |-> (row_out == ($past(row_out) << 1) || row_out == ROWS'(1)));

   // R2
   rest_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (row_out == ALL && col_sync == '0) |=> (row_out == ALL));

   // R2
   wake_row0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(row_out) == ALL && row_out != ALL) |-> (row_out == ROWS'(1)));

   // R4
   row_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (row_out != $past(row_out)) |-> $past(scan_tick));

   // R7
   irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      key_irq |=> !key_irq);

   // R7
   map_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (key_map != $past(key_map)) |-> key_irq);

   // R7
   irq_means_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      key_irq |-> (key_map != $past(key_map)));

   // R8
   rest_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(row_out) != ALL && row_out == ALL) |-> (key_map == '0));
endmodule

bind keymat_scan keymat_scan_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .scan_tick(scan_tick),
   .row_out  (row_out),
   .col_sync (col_sync),
   .key_map  (key_map),
   .key_irq  (key_irq)
);

// File: tb/sim_keymat_scan.sv
module sim_keymat_scan;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scan_tick = 1'b0;
   logic [3:0]  settle_ticks = 4'd1;
   logic [3:0]  stable_scans = 4'd1;
   logic [7:0]  col_in;
   logic [7:0]  row_out;
   logic [63:0] key_map;
   logic        key_irq;
   logic [63:0] keys = '0;

   int  n_chk = 0;
   int  n_err = 0;
   bit  done = 0;

   logic [63:0] map_at_irq;
   logic [7:0]  row_at_irq;

   // stimulus table: {key pattern, settle ticks, stable scans}
   localparam logic [71:0] VEC [6] = '{
      {64'h0000_0000_0000_0001, 4'd1, 4'd1},
      {64'h8000_0000_0000_0000, 4'd2, 4'd3},
      {64'h0808_0808_0808_0808, 4'd1, 4'd2},
      {64'h8040_2010_0804_0201, 4'd3, 4'd0},
      {64'hFFFF_FFFF_FFFF_FFFF, 4'd1, 4'd15},
      {64'h0000_00FF_0000_0000, 4'd2, 4'd4}
   };

   keymat_scan u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .scan_tick   (scan_tick),
      .settle_ticks(settle_ticks),
      .stable_scans(stable_scans),
      .col_in      (col_in),
      .row_out     (row_out),
      .key_map     (key_map),
      .key_irq     (key_irq)
   );

   always #10 clk = ~clk;

   // keypad model: a driven row shows its pressed keys on the columns
   always_comb begin
      col_in = '0;
      for (int r = 0; r < 8; r++)
         if (row_out[r]) col_in = col_in | keys[r*8 +: 8];
   end

   // scan tick: one cycle high every 6 clocks
   initial begin
      forever begin
         repeat (5) @(negedge clk);
         scan_tick = 1'b1;
         @(negedge clk);
         scan_tick = 1'b0;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wait_irq(input int limit, output int frames, output bit seen, output bit one_cycle);
      logic [7:0] prev;
      prev = row_out;
      frames = 0;
      seen = 0;
      one_cycle = 0;
      for (int i = 0; i < limit && !seen; i++) begin
         @(negedge clk);
         if (prev == 8'h80 && row_out != 8'h80) frames++;
         prev = row_out;
         if (key_irq) seen = 1;
      end
      if (seen) begin
         map_at_irq = key_map;
         row_at_irq = row_out;
         @(negedge clk);
         one_cycle = !key_irq;
      end
   endtask

   task automatic wait_frame_end(input int limit);
      logic [7:0] prev;
      prev = row_out;
      for (int i = 0; i < limit; i++) begin
         @(negedge clk);
         if (prev == 8'h80 && row_out != 8'h80) break;
         prev = row_out;
      end
   endtask

   task automatic release_all(input string tag);
      int  fr;
      bit  seen, one;
      keys = '0;
      wait_irq(20000, fr, seen, one);
      chk(seen, {"R7 release irq ", tag}, 64'(seen), 64'd1);
      chk(map_at_irq == '0, {"R7 release map ", tag}, map_at_irq, 64'd0);
      chk(row_at_irq == 8'hFF, {"R8 rest on empty ", tag}, 64'(row_at_irq), 64'hFF);
      repeat (30) @(negedge clk);
      chk(row_out == 8'hFF, {"R2 stays resting ", tag}, 64'(row_out), 64'hFF);
   endtask

   initial begin
      repeat (30000) @(negedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog R1..R8 actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      int  fr;
      bit  seen, one;
      int  need;
      logic [7:0] prevr;
      int  k, cyc, dur;
      bit  order_ok;
      bit  any_irq;

      // R1 reset state
      repeat (4) @(negedge clk);
      chk(row_out == 8'hFF, "R1 rows in reset", 64'(row_out), 64'hFF);
      chk(key_map == '0, "R1 map in reset", key_map, 64'd0);
      chk(!key_irq, "R1 irq in reset", 64'(key_irq), 64'd0);
      rst_n = 1'b1;
      repeat (20) @(negedge clk);
      chk(row_out == 8'hFF, "R1 rows after reset", 64'(row_out), 64'hFF);

      // table walk: R5 placement, R6 frame count from rest, R7 pulse
      for (int i = 0; i < 6; i++) begin
         settle_ticks = VEC[i][7:4];
         stable_scans = VEC[i][3:0];
         need = (VEC[i][3:0] == 0) ? 1 : int'(VEC[i][3:0]);
         keys = VEC[i][71:8];
         wait_irq(20000, fr, seen, one);
         chk(seen, "R7 press irq", 64'(seen), 64'd1);
         chk(map_at_irq == VEC[i][71:8], "R5 key map", map_at_irq, VEC[i][71:8]);
         chk(fr == need, "R6 frames to accept", 64'(fr), 64'(need));
         chk(one, "R7 one-cycle irq", 64'(one), 64'd1);
         release_all("table");
      end

      // R4 / R3 / R2: row order and hold time
      settle_ticks = 4'd3;
      stable_scans = 4'd1;
      keys = 64'h1;
      for (int i = 0; i < 200 && row_out == 8'hFF; i++) @(negedge clk);
      chk(row_out == 8'h01, "R2 first row", 64'(row_out), 64'h01);
      prevr = row_out;
      k = 0;
      cyc = 0;
      dur = 0;
      order_ok = 1;
      for (int i = 0; i < 2000 && k < 7; i++) begin
         @(negedge clk);
         cyc++;
         if (row_out != prevr) begin
            if (row_out != (8'h01 << (k + 1))) order_ok = 0;
            if (k == 1) dur = cyc;
            k++;
            cyc = 0;
            prevr = row_out;
         end
      end
      chk(order_ok && k == 7, "R3 row order", 64'(k), 64'd7);
      chk(dur == 18, "R4 row hold clocks", 64'(dur), 64'd18);
      wait_irq(2000, fr, seen, one);
      chk(map_at_irq == 64'h1, "R5 map after order run", map_at_irq, 64'h1);
      release_all("order");

      // R6 / R7 / R8: wake-up blip ends silently
      settle_ticks = 4'd1;
      stable_scans = 4'd2;
      keys = 64'h1;
      for (int i = 0; i < 200 && row_out == 8'hFF; i++) @(negedge clk);
      keys = '0;
      any_irq = 0;
      for (int i = 0; i < 2000 && row_out != 8'hFF; i++) begin
         @(negedge clk);
         if (key_irq) any_irq = 1;
      end
      chk(!any_irq, "R7 blip gives no irq", 64'(any_irq), 64'd0);
      chk(row_out == 8'hFF, "R8 blip returns to rest", 64'(row_out), 64'hFF);
      chk(key_map == '0, "R6 blip map", key_map, 64'd0);

      // R6: one-frame flicker while held is ignored, then a real change
      stable_scans = 4'd3;
      keys = 64'h1;
      wait_irq(5000, fr, seen, one);
      chk(map_at_irq == 64'h1, "R6 held map", map_at_irq, 64'h1);
      wait_frame_end(2000);
      keys = 64'h3;
      wait_frame_end(2000);
      keys = 64'h1;
      any_irq = 0;
      for (int j = 0; j < 6; j++) begin
         prevr = row_out;
         for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (key_irq) any_irq = 1;
            if (prevr == 8'h80 && row_out != 8'h80) break;
            prevr = row_out;
         end
      end
      chk(!any_irq, "R6 flicker no irq", 64'(any_irq), 64'd0);
      chk(key_map == 64'h1, "R6 flicker map kept", key_map, 64'h1);
      wait_frame_end(2000);
      keys = 64'h3;
      wait_irq(5000, fr, seen, one);
      chk(map_at_irq == 64'h3, "R7 changed map", map_at_irq, 64'h3);
      chk(fr == 3, "R6 frames after change", 64'(fr), 64'd3);
      chk(row_at_irq == 8'h01, "R8 nonempty keeps scanning", 64'(row_at_irq), 64'h01);
      release_all("flicker");

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
   end
endmodule